// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is a synthesizable target (slave) on a two-wire serial bus that fronts a 4096 x 8 byte store, kept as an internal register array. The system clock oversamples the bus clock and data lines, which pass through a synchronizer. The block drives the data line only through an open-drain pull-down enable. A bus master addresses the block with a device byte, then either supplies a two-byte word address followed by data to write, or reads bytes back from the internal address counter.

Written bytes are gathered in a one-page buffer and are committed only by a STOP that ends the write. The commit then runs as a self-timed write window of `WR_CYCLES` system clocks. During that window the block ignores its own device address, so a master can poll until the block acknowledges again. A write-protect input, sampled at the committing STOP, discards the buffered page. Three strap inputs give each target on a shared bus its own address.

The block has no streaming data edge, because all data moves over the serial pins. There is therefore no valid/ready interface and no back-pressure. The block never stretches the clock. The master paces every bit, and SCL must stay in each phase for at least four system clocks.

Top module: `twi_eeprom_target`

## Requirements
- R1: After reset, the SDA pull-down enable is off and every byte of the store reads as 0x00.
- R2: A device byte is accepted only if bits [7:4] are 4'b1010 and bits [3:1] equal the strap inputs. Bit 0 gives the direction: 0 is a write and 1 is a read. On a mismatch, the block does not acknowledge, and it ignores the bus until the next START.
- R3: The block acknowledges each byte it accepts by pulling SDA low for the whole ninth clock. Bits are transferred MSB first.
- R4: A write sends two word-address bytes after the device byte. The address is {first[3:0], second}, and first[7:4] is ignored.
- R5: Each data byte goes to the current page offset, and then only the low 5 address bits advance. Bytes past the page end therefore wrap within the same 32-byte page, and a later byte at the same offset replaces an earlier one.
- R6: Buffered data is written only by a STOP. A START, whether repeated or not, discards it. A write sequence that has no data byte commits nothing and opens no write window.
- R7: If the write-protect input is high at the committing STOP, the page is discarded, the store is left unchanged and no write window opens.
- R8: A committing STOP opens a write window of WR_CYCLES clocks. No device byte is acknowledged inside the window.
- R9: A read returns the byte at the address counter, and the counter then advances by one. The counter wraps from 4095 to 0. It supports current-address, random (dummy write of the address, then a repeated START) and sequential reads.
- R10: When the master does not acknowledge a read byte, the block releases SDA and ignores all clocks until START or STOP. The address counter keeps its value. A STOP always releases SDA.
- R11: The pull-down enable changes only while SCL is low. It is turned on only after the block has seen SCL low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire (resolved) |
| strap_i | input | 3 | Address straps compared with device byte bits [3:1] |
| wp_i | input | 1 | Write protect: high blocks commits |
| sda_oe_o | output | 1 | Pull-down enable for the data line (1 drives low) |

## Verification
The bench builds the block with the default 12-bit address and 32-byte page, and with WR_CYCLES set to 200. A poll issued right after a committing STOP then falls inside the write window, and a later poll falls outside it. Keeping the full-size store brings the 4095-to-0 wrap of the read counter within reach. The same setup covers a page write that wraps past the page end. The bench models the store, the address counter and the expected pull-down level for every bit. It compares these with the enable on every clock of each SCL-high phase.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DEV,
    S_AHI,
    S_ALO,
    S_WR,
    S_RD,
    S_SKIP
  } link_st_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh;
  logic [STAGES-1:0] sda_sh;
  logic              scl_p;
  logic              sda_p;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= scl_i;
          sda_sh <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= {scl_sh[STAGES-2:0], scl_i};
          sda_sh <= {sda_sh[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_q;
      sda_p <= sda_q;
    end
  end

  assign scl_q     = scl_sh[STAGES-1];
  assign sda_q     = sda_sh[STAGES-1];
  assign scl_rise  = scl_q & ~scl_p;
  assign scl_fall  = ~scl_q & scl_p;
  assign start_det = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_det  = scl_q & scl_p & ~sda_p & sda_q;

endmodule

// File: rtl/twi_write_timer.sv
module twi_write_timer #(
  parameter int WR_CYCLES = 50000,
  parameter int SLOT_W    = $clog2(WR_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  output logic              busy,
  output logic [SLOT_W-1:0] slot
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(WR_CYCLES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      slot <= '0;
    end else if (!busy) begin
      if (go) begin
        busy <= 1'b1;
        slot <= '0;
      end
    end else begin
      if (slot == LAST) busy <= 1'b0;
      slot <= slot + 1'b1;
    end
  end

endmodule

// File: rtl/twi_byte_store.sv
module twi_byte_store #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/twi_link_fsm.sv
module twi_link_fsm
  import twi_eeprom_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5,
  parameter int SLOT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_q,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [2:0]        strap_i,
  input  logic              wp_i,
  input  logic              busy,
  input  logic [SLOT_W-1:0] slot,
  input  logic [7:0]        rdata,
  output logic              sda_oe,
  output logic              commit_go,
  output logic              mem_we,
  output logic [ADDR_W-1:0] waddr,
  output logic [7:0]        wdata,
  output logic [ADDR_W-1:0] raddr
);
  localparam int PAGE = 1 << PAGE_W;
  localparam int HI_W = ADDR_W - 8;
  localparam int PG_W = ADDR_W - PAGE_W;

  link_st_e          st;
  link_st_e          st_nx;
  logic [3:0]        bitc;
  logic [7:0]        shreg;
  logic [7:0]        rdbyte;
  logic [ADDR_W-1:0] addr;
  logic [HI_W-1:0]   ahi;
  logic              mack;
  logic [PAGE-1:0]   mask;
  logic [PAGE-1:0]   cmask;
  logic [PG_W-1:0]   cpage;
  logic [7:0]        pbuf [PAGE];

  logic              rx_st;
  logic              live;
  logic              dev_hit;
  logic [PAGE_W-1:0] slot_ix;

  assign rx_st   = (st == S_DEV) || (st == S_AHI) || (st == S_ALO) || (st == S_WR);
  assign live    = (st != S_IDLE) && (st != S_SKIP);
  assign dev_hit = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == strap_i) && !busy;

  // Commit request: STOP with buffered data, not protected.
  assign commit_go = stop_det && (|mask) && !wp_i && !busy;

  // The write window drains the page snapshot, one byte per clock.
  assign slot_ix = slot[PAGE_W-1:0];
  assign mem_we  = busy && (slot < SLOT_W'(PAGE)) && cmask[slot_ix];
  assign waddr   = {cpage, slot_ix};
  assign wdata   = pbuf[slot_ix];
  assign raddr   = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      st_nx  <= S_IDLE;
      bitc   <= '0;
      shreg  <= '0;
      rdbyte <= '0;
      addr   <= '0;
      ahi    <= '0;
      mack   <= 1'b0;
      mask   <= '0;
      cmask  <= '0;
      cpage  <= '0;
      sda_oe <= 1'b0;
      for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
    end else if (start_det) begin
      st     <= S_DEV;
      bitc   <= '0;
      sda_oe <= 1'b0;
      mask   <= '0;
    end else if (stop_det) begin
      st     <= S_IDLE;
      bitc   <= '0;
      sda_oe <= 1'b0;
      mask   <= '0;
      if (commit_go) begin
        cmask <= mask;
        cpage <= addr[ADDR_W-1:PAGE_W];
      end
    end else if (scl_rise) begin
      if (rx_st && bitc < 4'd8) shreg <= {shreg[6:0], sda_q};
      if (st == S_RD && bitc == 4'd8) mack <= ~sda_q;
      if (live && bitc != 4'd9) bitc <= bitc + 4'd1;
    end else if (scl_fall && live) begin
      if (bitc == 4'd8) begin
        case (st)
          S_DEV: begin
            sda_oe <= dev_hit;
            if (!dev_hit)      st_nx <= S_SKIP;
            else if (shreg[0]) st_nx <= S_RD;
            else               st_nx <= S_AHI;
          end
          S_AHI: begin
            sda_oe <= 1'b1;
            ahi    <= shreg[HI_W-1:0];
            st_nx  <= S_ALO;
          end
          S_ALO: begin
            sda_oe <= 1'b1;
            addr   <= {ahi, shreg};
            st_nx  <= S_WR;
          end
          S_WR: begin
            sda_oe                  <= 1'b1;
            pbuf[addr[PAGE_W-1:0]]  <= shreg;
            mask[addr[PAGE_W-1:0]]  <= 1'b1;
            addr[PAGE_W-1:0]        <= addr[PAGE_W-1:0] + 1'b1;
            st_nx                   <= S_WR;
          end
          S_RD: begin
            sda_oe <= 1'b0;
            addr   <= addr + 1'b1;
            st_nx  <= S_RD;
          end
          default: begin
            sda_oe <= 1'b0;
            st_nx  <= S_SKIP;
          end
        endcase
      end else if (bitc == 4'd9) begin
        bitc <= '0;
        if (st_nx == S_RD && (st == S_DEV || mack)) begin
          st     <= S_RD;
          rdbyte <= rdata;
          sda_oe <= ~rdata[7];
        end else if (st_nx == S_RD) begin
          st     <= S_SKIP;
          sda_oe <= 1'b0;
        end else begin
          st     <= st_nx;
          sda_oe <= 1'b0;
        end
      end else if (st == S_RD) begin
        sda_oe <= ~rdbyte[3'd7 - bitc[2:0]];
      end
    end
  end

endmodule

// File: rtl/twi_eeprom_target.sv
module twi_eeprom_target #(
  parameter int ADDR_W      = 12,
  parameter int PAGE_W      = 5,
  parameter int WR_CYCLES   = 50000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);
  localparam int SLOT_W = $clog2(WR_CYCLES + 1);

  logic              scl_q;
  logic              sda_q;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic              busy;
  logic              commit_go;
  logic              mem_we;
  logic [SLOT_W-1:0] slot;
  logic [ADDR_W-1:0] waddr;
  logic [ADDR_W-1:0] raddr;
  logic [7:0]        wdata;
  logic [7:0]        rdata;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_q     (scl_q),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  twi_link_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SLOT_W(SLOT_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .strap_i   (strap_i),
    .wp_i      (wp_i),
    .busy      (busy),
    .slot      (slot),
    .rdata     (rdata),
    .sda_oe    (sda_oe_o),
    .commit_go (commit_go),
    .mem_we    (mem_we),
    .waddr     (waddr),
    .wdata     (wdata),
    .raddr     (raddr)
  );

  twi_write_timer #(.WR_CYCLES(WR_CYCLES), .SLOT_W(SLOT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (commit_go),
    .busy  (busy),
    .slot  (slot)
  );

  twi_byte_store #(.ADDR_W(ADDR_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (raddr),
    .rdata (rdata)
  );

endmodule

// File: rtl/twi_eeprom_target_chk.sv
module twi_eeprom_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_q,
  input logic stop_det,
  input logic wp_i,
  input logic busy,
  input logic sda_oe_o
);

  AST_DRIVE_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !$past(scl_q)); // R11

  AST_RELEASE_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe_o); // R10

  AST_WINDOW_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det)); // R6

  AST_PROTECT_NO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wp_i)); // R7

  AST_SILENT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !$past(busy)); // R8

endmodule

bind twi_eeprom_target twi_eeprom_target_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_q    (scl_q),
  .stop_det (stop_det),
  .wp_i     (wp_i),
  .busy     (busy),
  .sda_oe_o (sda_oe_o)
);

// File: tb/tb_twi_eeprom_target.sv
module tb_twi_eeprom_target;
  localparam int ADDR_W = 12;
  localparam int PAGE_W = 5;
  localparam int WR_CYC = 200;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE   = 1 << PAGE_W;
  localparam logic [2:0] MY_STRAP = 3'b101;

  typedef logic [7:0] byte_q_t[$];

  logic       clk   = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl   = 1'b1;
  logic       sda_m = 1'b1;
  logic       wp    = 1'b0;
  logic [2:0] strap = MY_STRAP;
  logic       sda_oe;
  logic       sda_line;

  assign sda_line = sda_m & ~sda_oe;
  always #5 clk = ~clk;

  twi_eeprom_target #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYC)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl),
    .sda_i    (sda_line),
    .strap_i  (strap),
    .wp_i     (wp),
    .sda_oe_o (sda_oe)
  );

  int         errors = 0;
  int         checks = 0;
  bit         done   = 0;
  logic [7:0] model_mem [DEPTH];
  int         model_addr = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One bit period: 8 clocks low (data set at mid-low), 8 clocks high.
  task automatic bus_bit(input logic b, input logic e_oe, input string req, output logic got);
    logic first;
    tick(4); sda_m = b; tick(4);
    scl = 1'b1; tick(3);
    first = sda_oe;
    for (int k = 0; k < 5; k++) begin
      chk(sda_oe === e_oe, req, "pull-down level", int'(sda_oe), int'(e_oe));
      chk(sda_oe === first, "R11", "change while SCL high", int'(sda_oe), int'(first));
      tick(1);
    end
    got = sda_line;
    scl = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(4);
    scl = 1'b1; tick(4);
    sda_m = 1'b0; tick(4);
    scl = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(4);
    scl = 1'b1; tick(4);
    sda_m = 1'b1; tick(8);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic e_ack, input string req);
    logic g;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], 1'b0, req, g);
    bus_bit(1'b1, e_ack, req, g);
  endtask

  task automatic recv_byte(input logic [7:0] e, input logic m_ack, input logic active, input string req);
    logic [7:0] got;
    logic g;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, active ? ~e[i] : 1'b0, req, g);
      got[i] = g;
    end
    if (active) chk(got == e, req, "read byte", int'(got), int'(e));
    bus_bit(~m_ack, 1'b0, req, g);
  endtask

  function automatic logic [7:0] dev_byte(input logic [2:0] s, input logic rw);
    return {4'b1010, s, rw};
  endfunction

  task automatic write_seq(input logic [15:0] raw, input byte_q_t data, input logic [2:0] s,
                           input bit wait_done, input string req);
    bit hit;
    int a;
    int base;
    hit = (s == MY_STRAP);
    bus_start();
    send_byte(dev_byte(s, 1'b0), hit, "R2");
    send_byte(raw[15:8], hit, "R4");
    send_byte(raw[7:0], hit, "R4");
    foreach (data[i]) send_byte(data[i], hit, req);
    bus_stop();
    if (hit) begin
      a    = int'(raw) & (DEPTH - 1);
      base = a & ~(PAGE - 1);
      if (!wp) begin
        foreach (data[i]) model_mem[base | ((a + i) & (PAGE - 1))] = data[i];
      end
      model_addr = base | ((a + data.size()) & (PAGE - 1));
      if (data.size() > 0 && !wp && wait_done) tick(WR_CYC + 20);
    end
  endtask

  task automatic read_bytes(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      recv_byte(model_mem[model_addr], i < n - 1, 1'b1, req);
      model_addr = (model_addr + 1) % DEPTH;
    end
    bus_stop();
  endtask

  task automatic rand_read(input int a, input int n, input string req);
    bus_start();
    send_byte(dev_byte(MY_STRAP, 1'b0), 1'b1, "R2");
    send_byte(8'(a >> 8), 1'b1, "R4");
    send_byte(8'(a), 1'b1, "R4");
    bus_start();
    send_byte(dev_byte(MY_STRAP, 1'b1), 1'b1, "R2");
    model_addr = a % DEPTH;
    read_bytes(n, req);
  endtask

  task automatic cur_read(input int n, input string req);
    bus_start();
    send_byte(dev_byte(MY_STRAP, 1'b1), 1'b1, "R2");
    read_bytes(n, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    byte_q_t q;
    for (int i = 0; i < DEPTH; i++) model_mem[i] = 8'h00;
    tick(5);
    // R1: reset state of the pull-down enable
    chk(sda_oe === 1'b0, "R1", "enable during reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    tick(5);
    chk(sda_oe === 1'b0, "R1", "enable after reset", int'(sda_oe), 0);
    // R1: store reads back zero
    rand_read(12'h010, 2, "R1");

    // R3 R4: single byte write then random read
    q = {}; q.push_back(8'hA5);
    write_seq(16'h0123, q, MY_STRAP, 1, "R3");
    rand_read(12'h123, 1, "R9");

    // R8: poll inside the write window is refused, later accepted
    q = {}; q.push_back(8'h3C);
    write_seq(16'h0200, q, MY_STRAP, 0, "R6");
    bus_start();
    send_byte(dev_byte(MY_STRAP, 1'b0), 1'b0, "R8");
    bus_stop();
    tick(WR_CYC + 20);
    rand_read(12'h200, 1, "R8");

    // R5: 35 bytes from page offset 30 wrap inside the page
    q = {};
    for (int i = 0; i < 35; i++) q.push_back(8'(i * 7 + 1));
    write_seq(16'h00BE, q, MY_STRAP, 1, "R5");
    rand_read(12'h0A0, PAGE, "R5");

    // R9: sequential read wraps from 4095 to 0, then current-address read
    q = {}; q.push_back(8'h11); q.push_back(8'h22);
    write_seq(16'h0FFE, q, MY_STRAP, 1, "R5");
    q = {}; q.push_back(8'h33);
    write_seq(16'h0000, q, MY_STRAP, 1, "R5");
    rand_read(12'hFFE, 3, "R9");
    cur_read(2, "R9");

    // R4: upper nibble of the first address byte is ignored
    q = {}; q.push_back(8'h6E);
    write_seq(16'hF340, q, MY_STRAP, 1, "R4");
    rand_read(12'h340, 1, "R4");

    // R2: mismatched strap, nothing acknowledged, no write window
    q = {}; q.push_back(8'h5A);
    write_seq(16'h0300, q, 3'b011, 1, "R2");
    rand_read(12'h300, 1, "R2");

    // R7: protected write is dropped with no window
    wp = 1'b1;
    q = {}; q.push_back(8'h77);
    write_seq(16'h0050, q, MY_STRAP, 1, "R7");
    tick(4);
    wp = 1'b0;
    rand_read(12'h050, 1, "R7");

    // R6: repeated START aborts buffered data
    bus_start();
    send_byte(dev_byte(MY_STRAP, 1'b0), 1'b1, "R6");
    send_byte(8'h00, 1'b1, "R6");
    send_byte(8'h60, 1'b1, "R6");
    send_byte(8'h99, 1'b1, "R6");
    send_byte(8'h98, 1'b1, "R6");
    bus_start();
    send_byte(dev_byte(MY_STRAP, 1'b1), 1'b1, "R6");
    model_addr = 12'h062;
    read_bytes(1, "R6");
    rand_read(12'h060, 2, "R6");

    // R10: master NACK ends the read; further clocks are ignored
    rand_read(12'h0A0, 1, "R10");
    bus_start();
    send_byte(dev_byte(MY_STRAP, 1'b1), 1'b1, "R10");
    recv_byte(model_mem[model_addr], 1'b0, 1'b1, "R10");
    model_addr = (model_addr + 1) % DEPTH;
    recv_byte(8'h00, 1'b1, 1'b0, "R10");
    bus_stop();
    chk(sda_oe === 1'b0, "R10", "released after STOP", int'(sda_oe), 0);
    cur_read(1, "R10");

    tick(10);
    finish_run();
  end

endmodule